// File: doc/BRIEF.md
# Round-Robin Fair Hardware Thread Lock

This block is a global mutual-exclusion lock shared by a parameterised number of hardware threads. One copy is used for each protected resource. Each thread sends one-cycle pulses to ask for the lock or to give it back. The block tracks every thread in one of four states: free, waiting, queued or owner. It reports the outcome on per-thread outputs:

- a halt level that the pipeline uses to stall the thread;
- a one-cycle wake pulse;
- a one-cycle done pulse that lets the lock instruction retire;
- one-cycle error pulses.

A single locked bit tells whether the lock is held.

When the owner releases the lock, the block does not reopen it to everyone. It hands it straight to the next waiting thread in circular order, starting from the releaser's index plus one. That thread moves to the queued state, stops being halted and receives a wake pulse. It then re-issues its lock request to become owner. A thread that requests a lock it already owns is flagged and halted, so the fault is visible instead of a silent deadlock. All results are registered: a request at one clock edge shows on the outputs in the following cycle.

Top module: `rr_thread_lock`

## Requirements
- R1: A synchronous active-high reset makes every thread free, clears the locked bit, and deasserts all halt, wake, done and error outputs.
- R2: A lock request from a free thread while no thread owns or is queued for the lock makes it owner. In the next cycle its done pulse is high and the locked bit is set.
- R3: A lock request from a free thread while the lock is held or queued puts it in waiting. Its halt output stays high until it is handed the lock, and it gets no done pulse.
- R4: A queued thread that issues a lock request becomes owner and receives a done pulse. The locked bit stays set.
- R5: An owner that requests the lock again gets a double-lock error pulse and a done pulse. Its halt output then stays high until reset, and it remains owner.
- R6: A valid unlock from the owner while no thread is waiting frees the owner and clears the locked bit in the next cycle.
- R7: An unlock request from a thread that is not owner changes no state and raises that thread's illegal-unlock error pulse in the next cycle.
- R8: On a valid unlock with waiters present, the first waiting thread found in circular order from the releaser's index plus one (modulo N) becomes queued. In the next cycle its wake pulse is high and its halt is low, and the locked bit stays set.
- R9: An unlock and lock requests in the same cycle are ordered unlock first. If the unlock hands the lock to a waiter, a new requester enters waiting.
- R10: When several free threads request a lock that is free after unlock processing, the lowest index becomes owner and the others enter waiting.
- R11: At most one thread is owner or queued at any time, and the locked bit is set exactly when one is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_req_i | input | N | Per-thread one-cycle lock request |
| unlock_req_i | input | N | Per-thread one-cycle unlock request |
| halt_o | output | N | Per-thread stall level (waiting, or halted after a double lock) |
| wake_o | output | N | Per-thread one-cycle pulse when the lock is handed to the thread |
| done_o | output | N | Per-thread one-cycle pulse telling the pipeline to retire the lock instruction |
| locked_o | output | 1 | Lock held by an owner or reserved for a queued thread |
| err_double_o | output | N | Per-thread one-cycle double-lock error pulse |
| err_unlock_o | output | N | Per-thread one-cycle illegal-unlock error pulse |

## Verification
A behavioural reference model is run alongside the block and compared with it on every cycle. The stimulus is chosen so that each pattern separates one rule from its neighbours:

- **Waiters on both sides of the releaser:** with waiters at indices 0 and 3 and a release from index 1, thread 3 must win. This separates a circular search from a lowest-index one.
- **Release from the highest index:** this exercises wrap-around of the search.
- **Release in the same cycle as a new request:** this separates unlock-first ordering from letting a newcomer jump ahead of a waiter.
- **Two requests at a free lock:** this exposes the tie-break.
- **Second request from the owner:** this exposes the double-lock path.
- **Unlock from a thread that does not own the lock:** this exposes the illegal-unlock path.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic [1:0] {
    LK_FREE   = 2'd0,
    LK_WAIT   = 2'd1,
    LK_QUEUED = 2'd2,
    LK_OWNER  = 2'd3
  } lk_state_t;
endpackage

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic [N-1:0]  pick
);
  // First set bit of m met when walking from index s upward, wrapping at N.
  function automatic logic [N-1:0] rotate_pick(input logic [N-1:0] m, input int s);
    logic [N-1:0] r;
    int j;
    r = '0;
    for (int k = N - 1; k >= 0; k--) begin
      j = (s + k) % N;
      if (m[j]) r = N'(1) << j;
    end
    return r;
  endfunction

  always_comb pick = rotate_pick(req, int'(start));

  always_comb begin
    p_pick_onehot_r8: assert ($onehot0(pick));
    p_pick_subset_r8: assert ((pick & ~req) == '0);
  end
endmodule

// File: rtl/lock_slot.sv
module lock_slot
  import lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lock_req,
  input  logic      unlock_req,
  input  logic      hand_win,
  input  logic      free_win,
  output lk_state_t state_o,
  output logic      halt_o,
  output logic      done_o,
  output logic      err_dbl_o
);
  lk_state_t st, st_n;
  logic      done_n, dbl_n, stuck;

  always_comb begin
    st_n   = st;
    done_n = 1'b0;
    dbl_n  = 1'b0;
    unique case (st)
      LK_FREE: if (lock_req) begin
        st_n   = free_win ? LK_OWNER : LK_WAIT;
        done_n = free_win;
      end
      LK_WAIT: if (hand_win) st_n = LK_QUEUED;
      LK_QUEUED: if (lock_req) begin
        st_n   = LK_OWNER;
        done_n = 1'b1;
      end
      LK_OWNER: begin
        if (unlock_req) begin
          if (lock_req) begin
            st_n   = free_win ? LK_OWNER : LK_WAIT;
            done_n = free_win;
          end else begin
            st_n = LK_FREE;
          end
        end else if (lock_req) begin
          dbl_n  = 1'b1;
          done_n = 1'b1;
        end
      end
      default: st_n = LK_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= LK_FREE;
      done_o    <= 1'b0;
      err_dbl_o <= 1'b0;
      stuck     <= 1'b0;
    end else begin
      st        <= st_n;
      done_o    <= done_n;
      err_dbl_o <= dbl_n;
      if (dbl_n) stuck <= 1'b1;
    end
  end

  assign state_o = st;
  assign halt_o  = (st == LK_WAIT) || stuck;

  p_dbl_halt_r5: assert property (@(posedge clk) disable iff (rst)
    err_dbl_o |-> (halt_o && st == LK_OWNER));
  p_illegal_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (unlock_req && st != LK_OWNER && !lock_req && !hand_win) |=> (st == $past(st)));
  p_queued_take_r4: assert property (@(posedge clk) disable iff (rst)
    (st == LK_QUEUED && lock_req) |=> (st == LK_OWNER && done_o));
  p_wait_halts_r3: assert property (@(posedge clk) disable iff (rst)
    (st == LK_WAIT) |-> (halt_o && !unlock_req));
endmodule

// File: rtl/rr_thread_lock.sv
module rr_thread_lock
  import lock_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lock_req_i,
  input  logic [N-1:0] unlock_req_i,
  output logic [N-1:0] halt_o,
  output logic [N-1:0] wake_o,
  output logic [N-1:0] done_o,
  output logic         locked_o,
  output logic [N-1:0] err_double_o,
  output logic [N-1:0] err_unlock_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  lk_state_t     st_vec [N];
  logic [N-1:0]  owner_vec, queued_vec, wait_vec, free_vec;
  logic [N-1:0]  rel_vec, bad_unlock_vec, hand_vec, free_req_vec, free_pick, free_win_vec;
  logic          rel_valid, busy_after;
  logic [IW-1:0] rel_idx, hand_start;

  for (genvar g = 0; g < N; g++) begin : g_cls
    assign owner_vec[g]  = (st_vec[g] == LK_OWNER);
    assign queued_vec[g] = (st_vec[g] == LK_QUEUED);
    assign wait_vec[g]   = (st_vec[g] == LK_WAIT);
    assign free_vec[g]   = (st_vec[g] == LK_FREE);
  end

  // Unlock stage: only the owner may release.
  assign rel_vec        = unlock_req_i & owner_vec;
  assign bad_unlock_vec = unlock_req_i & ~owner_vec;
  assign rel_valid      = |rel_vec;

  always_comb begin
    rel_idx = '0;
    for (int i = 0; i < N; i++) if (rel_vec[i]) rel_idx = IW'(i);
    hand_start = (int'(rel_idx) == N - 1) ? '0 : rel_idx + 1'b1;
  end

  logic [N-1:0] hand_pick;
  rr_picker #(.N(N)) u_hand (.req(wait_vec), .start(hand_start), .pick(hand_pick));
  assign hand_vec = rel_valid ? hand_pick : '0;

  // Lock stage, seen after the unlock stage.
  assign busy_after   = |((owner_vec & ~rel_vec) | queued_vec | hand_vec);
  assign free_req_vec = lock_req_i & (free_vec | rel_vec);
  rr_picker #(.N(N)) u_free (.req(free_req_vec), .start('0), .pick(free_pick));
  assign free_win_vec = busy_after ? '0 : free_pick;

  for (genvar g = 0; g < N; g++) begin : g_slot
    lock_slot u_slot (
      .clk       (clk),
      .rst       (rst),
      .lock_req  (lock_req_i[g]),
      .unlock_req(unlock_req_i[g]),
      .hand_win  (hand_vec[g]),
      .free_win  (free_win_vec[g]),
      .state_o   (st_vec[g]),
      .halt_o    (halt_o[g]),
      .done_o    (done_o[g]),
      .err_dbl_o (err_double_o[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_o     <= 1'b0;
      wake_o       <= '0;
      err_unlock_o <= '0;
    end else begin
      locked_o     <= busy_after | (|free_win_vec);
      wake_o       <= hand_vec;
      err_unlock_o <= bad_unlock_vec;
    end
  end

  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    $countones(owner_vec | queued_vec) <= 1);
  p_locked_match_r11: assert property (@(posedge clk) disable iff (rst)
    locked_o == (|(owner_vec | queued_vec)));
  p_wake_target_r8: assert property (@(posedge clk) disable iff (rst)
    (|wake_o) |-> ($onehot0(wake_o) && locked_o && ((wake_o & queued_vec) == wake_o) && ((wake_o & halt_o) == '0)));
  p_handoff_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (rel_valid && |wait_vec) |=> (locked_o && |wake_o));
  p_release_frees_r6: assert property (@(posedge clk) disable iff (rst)
    (rel_valid && wait_vec == '0 && lock_req_i == '0) |=> !locked_o);
  p_bad_unlock_r7: assert property (@(posedge clk) disable iff (rst)
    (|bad_unlock_vec) |=> (err_unlock_o != '0));
endmodule

// File: tb/sim_rr_thread_lock.sv
`timescale 1ns/1ps
module sim_rr_thread_lock;
  localparam int N = 4;
  localparam int FR = 0, WT = 1, QU = 2, OW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] lock_req = '0, unlock_req = '0;
  logic [N-1:0] halt, wake, done, err_double, err_unlock;
  logic locked;

  always #2 clk = ~clk;

  rr_thread_lock #(.N(N)) u0 (
    .clk(clk), .rst(rst), .lock_req_i(lock_req), .unlock_req_i(unlock_req),
    .halt_o(halt), .wake_o(wake), .done_o(done), .locked_o(locked),
    .err_double_o(err_double), .err_unlock_o(err_unlock));

  int checks = 0, failures = 0;
  bit finished = 0;

  // Reference model
  int st [N];
  bit dbl [N];
  logic [N-1:0] e_done, e_wake, e_ed, e_eu;
  logic e_locked;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin st[i] = FR; dbl[i] = 0; end
      e_done = '0; e_wake = '0; e_ed = '0; e_eu = '0; e_locked = 0;
    end else begin
      int rel;
      bit handed, busy;
      e_done = '0; e_wake = '0; e_ed = '0; e_eu = '0;
      rel = -1;
      for (int i = 0; i < N; i++)
        if (unlock_req[i]) begin
          if (st[i] == OW) rel = i; else e_eu[i] = 1;
        end
      if (rel >= 0) begin
        st[rel] = FR;
        handed = 0;
        for (int k = 1; k <= N; k++) begin
          int j;
          j = (rel + k) % N;
          if (!handed && st[j] == WT) begin st[j] = QU; e_wake[j] = 1; handed = 1; end
        end
      end
      busy = 0;
      for (int i = 0; i < N; i++) if (st[i] == OW || st[i] == QU) busy = 1;
      for (int i = 0; i < N; i++)
        if (lock_req[i]) begin
          if (st[i] == QU) begin st[i] = OW; e_done[i] = 1; end
          else if (st[i] == OW) begin e_ed[i] = 1; e_done[i] = 1; dbl[i] = 1; end
          else if (st[i] == FR) begin
            if (!busy) begin st[i] = OW; e_done[i] = 1; busy = 1; end
            else st[i] = WT;
          end
        end
      e_locked = busy;
    end
  end

  function automatic logic [N-1:0] exp_halt();
    logic [N-1:0] h;
    for (int i = 0; i < N; i++) h[i] = (st[i] == WT) || dbl[i];
    return h;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 done", 32'(done), 32'(e_done));
    chk("R11 locked", 32'(locked), 32'(e_locked));
    chk("R3 halt", 32'(halt), 32'(exp_halt()));
    chk("R8 wake", 32'(wake), 32'(e_wake));
    chk("R5 err_double", 32'(err_double), 32'(e_ed));
    chk("R7 err_unlock", 32'(err_unlock), 32'(e_eu));
  endtask

  // Called at a negedge; applies one cycle of requests, returns at the next negedge.
  task automatic step(input logic [N-1:0] lk, input logic [N-1:0] ul);
    lock_req = lk; unlock_req = ul;
    @(negedge clk);
    lock_req = '0; unlock_req = '0;
    compare_all();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 halt", 32'(halt), 0);
    chk("R1 locked", 32'(locked), 0);
    chk("R1 pulses", 32'(done | wake | err_double | err_unlock), 0);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    step(4'b0000, 4'b0000);
    step(4'b0010, 4'b0000);                // T1 takes free lock
    chk("R2 done T1", 32'(done), 32'h2);
    chk("R2 locked", 32'(locked), 1);
    step(4'b0100, 4'b0000);                // T2 waits
    chk("R3 halt T2", 32'(halt), 32'h4);
    chk("R3 no done", 32'(done), 0);
    step(4'b0001, 4'b0000);                // T0 waits
    step(4'b0000, 4'b1000);                // T3 illegal unlock
    chk("R7 err T3", 32'(err_unlock), 32'h8);
    chk("R7 locked kept", 32'(locked), 1);
    step(4'b0000, 4'b0010);                // T1 releases, search from 2
    chk("R8 wake T2", 32'(wake), 32'h4);
    chk("R8 halt drop", 32'(halt), 32'h1);
    chk("R8 locked", 32'(locked), 1);
    step(4'b0100, 4'b0000);                // T2 queued -> owner
    chk("R4 done T2", 32'(done), 32'h4);
    step(4'b1000, 4'b0100);                // T2 release + T3 new request
    chk("R9 wake T0 wrap", 32'(wake), 32'h1);
    chk("R9 T3 waits", 32'(halt), 32'h8);
    step(4'b0001, 4'b0000);
    step(4'b0000, 4'b0001);                // T0 release -> T3
    chk("R8 wake T3", 32'(wake), 32'h8);
    step(4'b1000, 4'b0000);
    step(4'b0000, 4'b1000);                // T3 release, nobody waiting
    chk("R6 locked clear", 32'(locked), 0);
    step(4'b0110, 4'b0000);                // T1 and T2 both request
    chk("R10 T1 wins", 32'(done), 32'h2);
    chk("R10 T2 waits", 32'(halt), 32'h4);
    step(4'b0000, 4'b0010);
    step(4'b0100, 4'b0000);
    step(4'b0100, 4'b0000);                // T2 double lock
    chk("R5 err T2", 32'(err_double), 32'h4);
    chk("R5 done T2", 32'(done), 32'h4);
    step(4'b0000, 4'b0000);
    chk("R5 halt sticky", 32'(halt), 32'h4);
    do_reset();
    step(4'b0010, 4'b0000);                // circular order check
    step(4'b0001, 4'b0000);
    step(4'b1000, 4'b0000);
    step(4'b0000, 4'b0010);                // waiters 0,3; release 1 -> 3
    chk("R8 circular T3", 32'(wake), 32'h8);
    step(4'b1000, 4'b0000);
    step(4'b0000, 4'b1000);                // release 3 -> wraps to 0
    chk("R8 wrap T0", 32'(wake), 32'h1);
    repeat (3) step(4'b0000, 4'b0000);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule